// File: doc/BRIEF.md
# Radix Translation Root Locator

This block prepares a radix page-tree walk. Given a translation request it finds the root of the tree that belongs to the current partition and process. It does this with two chained table lookups over a 64-bit physical read port that allows one read in flight at a time. The first read fetches the second doubleword of the partition table entry, which names the process table. The second read fetches the first doubleword of the process table entry, which describes the tree root.

The effective partition ID and the effective process ID come from the privilege bits, the ID registers and the top two bits (the quadrant) of the virtual address. A quadrant that is illegal for the current mode ends the request at once with an error, and no memory read is made. When the request succeeds, the block reports the root directory base address, the root size code, and how many low virtual-address bits the tree translates. A one-cycle `done` pulse marks that result.

The controller has seven states. `ST_IDLE` accepts a request. `ST_PART_ISSUE` and `ST_PART_WAIT` issue the partition read and wait for its data. `ST_PROC_ISSUE` and `ST_PROC_WAIT` do the same for the process read. `ST_DONE` pulses the result and `ST_FAULT` pulses the error. The transitions are:
- `ST_IDLE` goes to `ST_PART_ISSUE` on a legal request, or to `ST_FAULT` on an illegal quadrant.
- Each ISSUE state goes to its WAIT state after one cycle.
- `ST_PART_WAIT` goes to `ST_PROC_ISSUE` when `rd_resp_valid` is high.
- `ST_PROC_WAIT` goes to `ST_DONE` when `rd_resp_valid` is high.
- `ST_DONE` and `ST_FAULT` return to `ST_IDLE`.

Top module: `radix_root_locator`

## Requirements
- R1: After reset the block is idle, with `rd_req_valid`, `done` and `err` low.
- R2: The first read address is {4'b0, ptcr[59:12], 12'b0} + 16*effective_LPID + 8.
- R3: The effective LPID is 0 when `msr_hv` is 1, and `lpid_reg` otherwise.
- R4: With `msr_hv`=1 and `msr_pr`=0, quadrants vaddr[63:62] = 2'b11 and 2'b10 give effective PID 0, and 2'b00 and 2'b01 give `pid_reg`.
- R5: In every other mode, quadrant 2'b11 gives effective PID 0 and quadrant 2'b00 gives `pid_reg`.
- R6: In the modes of R5, quadrants 2'b01 and 2'b10 cause a one-cycle pulse with `done`=1 and `err`=1 in the cycle after the request. No read is issued, and the block then returns to idle.
- R7: The second read address is {4'b0, P[59:12], 12'b0} + 16*effective_PID, where P is the data of the first read.
- R8: Each read is a one-cycle `rd_req_valid` pulse. The second read is issued in the cycle after the first response, and no further request pulse appears while a response is outstanding.
- R9: With E the data of the second read, `root_base` = {4'b0, E[59:8], 8'b0} and `root_size` = E[4:0].
- R10: `useful_bits` = {E[62:61], E[7:5]} + 31, for example 52 for code 21.
- R11: `done` is high for exactly one cycle, the cycle after the second response, with `err`=0. The result outputs hold their values until the next completion.
- R12: `req_valid` is ignored while a request is in progress. It starts no extra read and changes no address or result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, sampled in idle |
| req_vaddr | input | 64 | Virtual address; bits 63:62 select the quadrant |
| ptcr | input | 64 | Partition table control; bits 59:12 hold the table base |
| msr_hv | input | 1 | Hypervisor state bit |
| msr_pr | input | 1 | Problem (user) state bit |
| lpid_reg | input | LPID_W | Logical partition ID register |
| pid_reg | input | PID_W | Process ID register |
| rd_req_valid | output | 1 | Read request pulse |
| rd_addr | output | 64 | Physical byte address of the read |
| rd_resp_valid | input | 1 | Read data valid |
| rd_resp_data | input | 64 | Read data |
| done | output | 1 | Completion pulse |
| err | output | 1 | Quadrant error, high together with done |
| root_base | output | 64 | Root directory base address |
| root_size | output | 5 | Root directory size code |
| useful_bits | output | 7 | Number of translated virtual address bits |

## Verification
On every cycle the assertions check the following. Read requests and completion pulses last one cycle and never overlap. An error is never reported without `done`. Read addresses are doubleword aligned. A successful result has a zero-padded base and a useful-bit count of at least 31. The result outputs move only when `done` is high. Only the bench scenarios can show the quadrant-to-PID mapping for each privilege mode, the exact address arithmetic of both lookups, and that a request during a walk leaves the walk untouched. The bench checks these against its own reference functions, using both random and directed entries.

// File: rtl/rrl_pkg.sv
package rrl_pkg;
    localparam int ADDR_W     = 64;
    localparam int SIZE_W     = 5;
    localparam int USEFUL_W   = 7;
    localparam int RTS_BIAS   = 31;
    localparam int ENTRY_LOG2 = 4;   // 16-byte table entries
    localparam int WORD1_OFS  = 8;   // second doubleword of an entry

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PART_ISSUE,
        ST_PART_WAIT,
        ST_PROC_ISSUE,
        ST_PROC_WAIT,
        ST_DONE,
        ST_FAULT
    } rrl_state_e;
endpackage

// File: rtl/rrl_id_select.sv
module rrl_id_select #(
    parameter int LPID_W = 12,
    parameter int PID_W  = 20
) (
    input  logic              hv,
    input  logic              pr,
    input  logic [1:0]        quad,
    input  logic [LPID_W-1:0] lpid_reg,
    input  logic [PID_W-1:0]  pid_reg,
    output logic [LPID_W-1:0] eff_lpid,
    output logic [PID_W-1:0]  eff_pid,
    output logic              quad_err
);
    always_comb begin
        eff_lpid = hv ? '0 : lpid_reg;
        quad_err = 1'b0;
        eff_pid  = pid_reg;
        if (hv && !pr) begin
            // kernel-side hypervisor: upper half of the space is PID 0
            eff_pid = quad[1] ? '0 : pid_reg;
        end else begin
            unique case (quad)
                2'b11:   eff_pid = '0;
                2'b00:   eff_pid = pid_reg;
                default: begin
                    eff_pid  = '0;
                    quad_err = 1'b1;
                end
            endcase
        end
    end
endmodule

// File: rtl/rrl_addr_gen.sv
module rrl_addr_gen
    import rrl_pkg::*;
#(
    parameter int LPID_W = 12,
    parameter int PID_W  = 20
) (
    input  logic [ADDR_W-1:0] ptcr_q,
    input  logic [LPID_W-1:0] lpid_q,
    input  logic [ADDR_W-1:0] part_word_q,
    input  logic [PID_W-1:0]  pid_q,
    output logic [ADDR_W-1:0] part_addr,
    output logic [ADDR_W-1:0] proc_addr
);
    localparam int BASE_HI = 59;
    localparam int BASE_LO = 12;

    logic [ADDR_W-1:0] part_base;
    logic [ADDR_W-1:0] proc_base;
    logic [ADDR_W-1:0] lpid_ofs;
    logic [ADDR_W-1:0] pid_ofs;
    logic              unused_table_bits;

    assign part_base = {4'b0, ptcr_q[BASE_HI:BASE_LO], {BASE_LO{1'b0}}};
    assign proc_base = {4'b0, part_word_q[BASE_HI:BASE_LO], {BASE_LO{1'b0}}};
    assign lpid_ofs  = ADDR_W'(lpid_q) << ENTRY_LOG2;
    assign pid_ofs   = ADDR_W'(pid_q) << ENTRY_LOG2;

    assign part_addr = part_base + lpid_ofs + ADDR_W'(WORD1_OFS);
    assign proc_addr = proc_base + pid_ofs;

    assign unused_table_bits = ^{ptcr_q[ADDR_W-1:BASE_HI+1], ptcr_q[BASE_LO-1:0],
                                 part_word_q[ADDR_W-1:BASE_HI+1], part_word_q[BASE_LO-1:0]};
endmodule

// File: rtl/rrl_entry_decode.sv
module rrl_entry_decode
    import rrl_pkg::*;
(
    input  logic [ADDR_W-1:0]   entry,
    output logic [ADDR_W-1:0]   root_base,
    output logic [SIZE_W-1:0]   root_size,
    output logic [USEFUL_W-1:0] useful_bits
);
    logic [4:0] tree_code;
    logic       unused_entry_bits;

    assign root_base   = {4'b0, entry[59:8], 8'b0};
    assign root_size   = entry[SIZE_W-1:0];
    assign tree_code   = {entry[62:61], entry[7:5]};
    assign useful_bits = USEFUL_W'(tree_code) + USEFUL_W'(RTS_BIAS);

    assign unused_entry_bits = entry[63] ^ entry[60];
endmodule

// File: rtl/radix_root_locator.sv
module radix_root_locator
    import rrl_pkg::*;
#(
    parameter int LPID_W = 12,
    parameter int PID_W  = 20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [63:0]         req_vaddr,
    input  logic [63:0]         ptcr,
    input  logic                msr_hv,
    input  logic                msr_pr,
    input  logic [LPID_W-1:0]   lpid_reg,
    input  logic [PID_W-1:0]    pid_reg,
    output logic                rd_req_valid,
    output logic [63:0]         rd_addr,
    input  logic                rd_resp_valid,
    input  logic [63:0]         rd_resp_data,
    output logic                done,
    output logic                err,
    output logic [63:0]         root_base,
    output logic [4:0]          root_size,
    output logic [6:0]          useful_bits
);
    rrl_state_e state_q, state_d;

    logic [ADDR_W-1:0] ptcr_q;
    logic [LPID_W-1:0] lpid_q;
    logic [PID_W-1:0]  pid_q;
    logic [ADDR_W-1:0] part_word_q;
    logic [ADDR_W-1:0] proc_word_q;

    logic [LPID_W-1:0] eff_lpid;
    logic [PID_W-1:0]  eff_pid;
    logic              quad_err;
    logic [ADDR_W-1:0] part_addr;
    logic [ADDR_W-1:0] proc_addr;
    logic              unused_vaddr;

    assign unused_vaddr = ^req_vaddr[61:0];

    rrl_id_select #(.LPID_W(LPID_W), .PID_W(PID_W)) u_ids (
        .hv       (msr_hv),
        .pr       (msr_pr),
        .quad     (req_vaddr[63:62]),
        .lpid_reg (lpid_reg),
        .pid_reg  (pid_reg),
        .eff_lpid (eff_lpid),
        .eff_pid  (eff_pid),
        .quad_err (quad_err)
    );

    rrl_addr_gen #(.LPID_W(LPID_W), .PID_W(PID_W)) u_addr (
        .ptcr_q      (ptcr_q),
        .lpid_q      (lpid_q),
        .part_word_q (part_word_q),
        .pid_q       (pid_q),
        .part_addr   (part_addr),
        .proc_addr   (proc_addr)
    );

    rrl_entry_decode u_dec (
        .entry       (proc_word_q),
        .root_base   (root_base),
        .root_size   (root_size),
        .useful_bits (useful_bits)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:       if (req_valid) state_d = quad_err ? ST_FAULT : ST_PART_ISSUE;
            ST_PART_ISSUE: state_d = ST_PART_WAIT;
            ST_PART_WAIT:  if (rd_resp_valid) state_d = ST_PROC_ISSUE;
            ST_PROC_ISSUE: state_d = ST_PROC_WAIT;
            ST_PROC_WAIT:  if (rd_resp_valid) state_d = ST_DONE;
            ST_DONE:       state_d = ST_IDLE;
            ST_FAULT:      state_d = ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    // request context and fetched table words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptcr_q      <= '0;
            lpid_q      <= '0;
            pid_q       <= '0;
            part_word_q <= '0;
            proc_word_q <= '0;
        end else begin
            if (state_q == ST_IDLE && req_valid && !quad_err) begin
                ptcr_q <= ptcr;
                lpid_q <= eff_lpid;
                pid_q  <= eff_pid;
            end
            if (state_q == ST_PART_WAIT && rd_resp_valid) part_word_q <= rd_resp_data;
            if (state_q == ST_PROC_WAIT && rd_resp_valid) proc_word_q <= rd_resp_data;
        end
    end

    // outputs
    always_comb begin
        rd_req_valid = 1'b0;
        rd_addr      = proc_addr;
        done         = 1'b0;
        err          = 1'b0;
        unique case (state_q)
            ST_PART_ISSUE: begin rd_req_valid = 1'b1; rd_addr = part_addr; end
            ST_PART_WAIT:  rd_addr = part_addr;
            ST_PROC_ISSUE: rd_req_valid = 1'b1;
            ST_DONE:       done = 1'b1;
            ST_FAULT:      begin done = 1'b1; err = 1'b1; end
            default:       ;
        endcase
    end
endmodule

// File: rtl/rrl_checker.sv
module rrl_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        rd_req_valid,
    input logic [63:0] rd_addr,
    input logic        done,
    input logic        err,
    input logic [63:0] root_base,
    input logic [6:0]  useful_bits
);
    AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid |=> !rd_req_valid);                                  // R8
    AST_REQ_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid |-> !done);                                          // R8
    AST_ADDR_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid |-> rd_addr[2:0] == 3'b000);                         // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                                  // R11
    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done && !rd_req_valid);                                   // R6
    AST_BASE_PADDED: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err) |-> (root_base[7:0] == 8'h0 && root_base[63:60] == 4'h0)); // R9
    AST_USEFUL_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err) |-> useful_bits >= 7'd31);                         // R10
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(root_base));                                    // R11
endmodule

bind radix_root_locator rrl_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_req_valid(rd_req_valid),
    .rd_addr     (rd_addr),
    .done        (done),
    .err         (err),
    .root_base   (root_base),
    .useful_bits (useful_bits)
);

// File: tb/radix_root_locator_tb.sv
module radix_root_locator_tb;
    localparam int CLK_PERIOD = 10;
    localparam int LPID_W = 12;
    localparam int PID_W  = 20;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [63:0]       req_vaddr = '0;
    logic [63:0]       ptcr = '0;
    logic              msr_hv = 1'b0;
    logic              msr_pr = 1'b0;
    logic [LPID_W-1:0] lpid_reg = '0;
    logic [PID_W-1:0]  pid_reg = '0;
    logic              rd_req_valid;
    logic [63:0]       rd_addr;
    logic              rd_resp_valid = 1'b0;
    logic [63:0]       rd_resp_data = '0;
    logic              done, err;
    logic [63:0]       root_base;
    logic [4:0]        root_size;
    logic [6:0]        useful_bits;

    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    radix_root_locator #(.LPID_W(LPID_W), .PID_W(PID_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .ptcr(ptcr), .msr_hv(msr_hv), .msr_pr(msr_pr), .lpid_reg(lpid_reg),
        .pid_reg(pid_reg), .rd_req_valid(rd_req_valid), .rd_addr(rd_addr),
        .rd_resp_valid(rd_resp_valid), .rd_resp_data(rd_resp_data), .done(done),
        .err(err), .root_base(root_base), .root_size(root_size), .useful_bits(useful_bits)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] tbase(input logic [63:0] w);
        return {4'h0, w[59:12], 12'h000};
    endfunction

    // returns 1 on quadrant error
    function automatic bit ref_pid(input bit hv, input bit pr, input logic [1:0] q,
                                   input logic [PID_W-1:0] pid, output logic [PID_W-1:0] epid);
        epid = pid;
        if (hv && !pr) begin
            if (q[1]) epid = '0;
            return 1'b0;
        end
        if (q == 2'b11) begin epid = '0; return 1'b0; end
        if (q == 2'b00) return 1'b0;
        return 1'b1;
    endfunction

    function automatic logic [63:0] mk_prte(input logic [1:0] r1, input logic [2:0] r2,
                                            input logic [51:0] base, input logic [4:0] sz);
        return {1'b0, r1, 1'b0, base, r2, sz};
    endfunction

    task automatic txn(input logic [63:0] va, input logic [63:0] pt, input bit hv, input bit pr,
                       input logic [LPID_W-1:0] lp, input logic [PID_W-1:0] pd,
                       input logic [63:0] w1, input logic [63:0] w2,
                       input int lat1, input int lat2, input bit poke);
        logic [PID_W-1:0]  epid;
        logic [LPID_W-1:0] elpid;
        logic [63:0]       a1, a2, keep;
        bit                qerr;
        string             ptag;
        qerr  = ref_pid(hv, pr, va[63:62], pd, epid);
        elpid = hv ? '0 : lp;
        a1    = tbase(pt) + ({52'h0, elpid} << 4) + 64'd8;
        a2    = tbase(w1) + ({44'h0, epid} << 4);
        ptag  = (hv && !pr) ? "R4 R7" : "R5 R7";

        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; ptcr = pt; msr_hv = hv; msr_pr = pr;
        lpid_reg = lp; pid_reg = pd;
        @(negedge clk);
        req_valid = 1'b0;
        if (qerr) begin
            chk("R6 done", {63'h0, done}, 64'h1);
            chk("R6 err", {63'h0, err}, 64'h1);
            chk("R6 no read", {63'h0, rd_req_valid}, 64'h0);
            @(negedge clk);
            chk("R6 back idle", {62'h0, done, rd_req_valid}, 64'h0);
            return;
        end
        chk("R8 first req", {63'h0, rd_req_valid}, 64'h1);
        chk("R2 R3 partition addr", rd_addr, a1);
        if (poke) begin
            req_valid = 1'b1; req_vaddr = ~va; ptcr = ~pt; msr_hv = ~hv;
            lpid_reg = ~lp; pid_reg = ~pd;
        end
        for (int i = 0; i < lat1; i++) begin
            @(negedge clk);
            chk("R8 one outstanding", {63'h0, rd_req_valid}, 64'h0);
        end
        rd_resp_valid = 1'b1; rd_resp_data = w1;
        @(negedge clk);
        rd_resp_valid = 1'b0; rd_resp_data = '0; req_valid = 1'b0;
        chk("R8 second req", {63'h0, rd_req_valid}, 64'h1);
        chk(poke ? "R12 process addr" : ptag, rd_addr, a2);
        for (int i = 0; i < lat2; i++) begin
            @(negedge clk);
            chk("R8 wait second", {62'h0, rd_req_valid, done}, 64'h0);
        end
        rd_resp_valid = 1'b1; rd_resp_data = w2;
        @(negedge clk);
        rd_resp_valid = 1'b0; rd_resp_data = '0;
        chk("R11 done", {62'h0, done, err}, 64'h2);
        chk("R9 root base", root_base, {4'h0, w2[59:8], 8'h00});
        chk("R9 root size", {59'h0, root_size}, {59'h0, w2[4:0]});
        chk("R10 useful bits", {57'h0, useful_bits}, 64'd31 + {59'h0, w2[62:61], w2[7:5]});
        keep = root_base;
        @(negedge clk);
        chk("R11 done falls", {63'h0, done}, 64'h0);
        chk("R11 result held", root_base, keep);
        @(negedge clk);
        chk("R12 no extra read", {62'h0, rd_req_valid, done}, 64'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd5150));
        repeat (3) @(negedge clk);
        chk("R1 reset outputs", {61'h0, rd_req_valid, done, err}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset", {61'h0, rd_req_valid, done, err}, 64'h0);

        // hypervisor kernel, upper quadrant, tree code 21 -> 52 bits
        txn(64'hC000_0108_0000_3000, 64'h0000_0000_0001_0004, 1, 0, 12'h5, 20'h7,
            64'h0000_0000_0100_000B, mk_prte(2'b10, 3'b101, 52'h300, 5'd12), 1, 1, 0);
        // hypervisor user, quadrant 00 uses pid register
        txn(64'h0000_0000_0000_1000, 64'h0000_0000_0001_0004, 1, 1, 12'h9, 20'h1,
            64'h0000_0000_0100_000B, mk_prte(2'b10, 3'b101, 52'h300, 5'd13), 2, 3, 0);
        // guest, quadrant 11, partition id used, all-ones entry
        txn(64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 12'hFFF, 20'hFFFFF,
            64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1, 4, 0);
        // hypervisor kernel, quadrant 01 uses pid register
        txn(64'h4000_0000_0000_0000, 64'h0000_0000_0002_0000, 1, 0, 12'h1, 20'hABCDE,
            64'h0000_0000_0200_0000, mk_prte(2'b00, 3'b000, 52'h1, 5'd5), 3, 1, 0);
        // quadrant errors
        txn(64'h4000_0000_0000_0000, 64'h0, 1, 1, 12'h0, 20'h3, 64'h0, 64'h0, 1, 1, 0);
        txn(64'h8000_0000_0000_0000, 64'h0, 0, 0, 12'h2, 20'h3, 64'h0, 64'h0, 1, 1, 0);
        txn(64'h4123_0000_0000_0000, 64'h0, 0, 1, 12'h2, 20'h3, 64'h0, 64'h0, 1, 1, 0);
        // request during a walk
        txn(64'h0000_0000_1234_5000, 64'h0000_0000_0003_0000, 0, 1, 12'h44, 20'h55,
            64'h0000_0000_0400_0000, mk_prte(2'b01, 3'b011, 52'h4_5678, 5'd9), 4, 2, 1);

        for (int k = 0; k < 60; k++) begin
            txn({$urandom, $urandom}, {$urandom, $urandom}, 1'($urandom), 1'($urandom),
                LPID_W'($urandom), PID_W'($urandom), {$urandom, $urandom},
                {$urandom, $urandom}, 1 + int'($urandom % 4), 1 + int'($urandom % 4),
                1'($urandom));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule